// File: doc/BRIEF.md
# Prediction Block PC Store and Expander

This block keeps one address record for every entry of a fetch queue and turns any two-byte instruction slot of a prediction block back into a full 39-bit instruction address. A prediction block covers sixteen two-byte slots, or 32 bytes. A cache line holds 64 bytes, so a block begins either in the lower half or in the upper half of a line. Only a block that begins in the upper half can run into the following line.

Each record holds four fields, each in its own storage: the block start address, the address of the next cache line, a 16-bit per-slot line-crossing mask and a fall-through error flag. The block computes the mask itself when a record is written, from the start address. A record is written when the predictor creates a queue entry. A redirected block is written as a fresh entry, and records are never patched in place.

A read port loads the addressed record into an output register on every clock edge. Combinational logic then takes a 4-bit slot offset and forms the instruction PC from that registered record. There is no back-pressure on either side: a write is taken on every edge where `wr_valid` is high, and the read register reloads on every edge without a handshake.

Top module: `pc_block_store`

## Requirements
- R1: On a rising edge with `wr_valid` high, the record for entry `wr_idx` takes `wr_start`, `wr_next_line` and `wr_fall_err`. A later read of that entry returns exactly those values.
- R2: The stored crossing mask has bit n (n = 0..15) set exactly when `wr_start[5:1] + n` exceeds 31. The mask is therefore all zero whenever `wr_start[5]` is 0.
- R3: On every rising edge the read register loads the record of the entry that `rd_idx` selects. A change of `rd_idx` shows on the `rd_*` outputs only after the next edge.
- R4: When a write and a read select the same entry on one edge, the read register takes the newly written record rather than the old one.
- R5: `pc_out[0]` is 0, and `pc_out[5:1]` equals `(start[5:1] + slot_off) mod 32`, where start is the registered record.
- R6: When mask bit `slot_off` of the registered record is 0, `pc_out[38:6]` equals `start[38:6]` and `pc_crosses` is 0.
- R7: When mask bit `slot_off` is 1, `pc_out[38:6]` equals `next_line[38:6]` and `pc_crosses` is 1.
- R8: While reset is asserted, all stored records and the read register are cleared, so after reset every `rd_*` output and `pc_out` read zero.
- R9: Rewriting an entry replaces its whole record and leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write a new record this edge |
| wr_idx | input | IDX_W | Queue entry to write |
| wr_start | input | 39 | Block start address |
| wr_next_line | input | 39 | Next cache line address |
| wr_fall_err | input | 1 | Fall-through error flag |
| rd_idx | input | IDX_W | Queue entry to load into the read register |
| slot_off | input | 4 | Instruction slot within the registered block |
| rd_start | output | 39 | Registered start address |
| rd_next_line | output | 39 | Registered next line address |
| rd_mask | output | 16 | Registered crossing mask |
| rd_fall_err | output | 1 | Registered fall-through error flag |
| pc_out | output | 39 | Expanded instruction PC |
| pc_crosses | output | 1 | Selected slot lies in the next line |

## Verification
A written record can be seen one edge after the write, provided `rd_idx` already selects its entry at that edge; otherwise it appears one edge after `rd_idx` is driven. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. `pc_out` and `pc_crosses` depend combinationally on `slot_off`, so the bench sweeps all sixteen offsets inside one cycle and samples each 1 ns after setting it. The forwarding case and the delay of an address change are both checked in the cycle right after the edge, before the old entry could reach the outputs again. The main sweep covers all 64 values of the six low start-address bits against all offsets, on a small queue.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int ADDR_W   = 39;
  localparam int SLOTS    = 16;
  localparam int OFF_W    = $clog2(SLOTS);
  localparam int SUM_W    = OFF_W + 1;
  localparam int LINE_LSB = SUM_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] next_line;
    logic [SLOTS-1:0]  mask;
    logic              fall_err;
  } rec_t;
endpackage

// File: rtl/pcs_mask_gen.sv
module pcs_mask_gen
  import pcs_pkg::*;
(
  input  logic [ADDR_W-1:0] start_i,
  output logic [SLOTS-1:0]  mask_o
);
  localparam int WRAP = 2 ** SUM_W;

  logic [SUM_W-1:0] base_slot;
  assign base_slot = start_i[SUM_W:1];

  for (genvar n = 0; n < SLOTS; n++) begin : g_bit
    assign mask_o[n] = (int'(base_slot) + n) >= WRAP;
  end

  always_comb begin
    p_lowhalf_nocross_r2: assert (start_i[LINE_LSB-1] || mask_o == '0)
      else $error("crossing mask set for a lower-half block");
  end
endmodule

// File: rtl/pcs_store.sv
module pcs_store
  import pcs_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  rec_t             wr_rec,
  input  logic [IDX_W-1:0] rd_idx,
  output rec_t             rd_rec_o
);
  logic [ADDR_W-1:0] start_q [ENTRIES];
  logic [ADDR_W-1:0] next_q  [ENTRIES];
  logic [SLOTS-1:0]  mask_q  [ENTRIES];
  logic              ferr_q  [ENTRIES];
  rec_t              rd_q;
  logic              fwd;

  assign fwd = wr_valid && (wr_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        start_q[e] <= '0;
        next_q[e]  <= '0;
        mask_q[e]  <= '0;
        ferr_q[e]  <= 1'b0;
      end
      rd_q <= '0;
    end else begin
      if (wr_valid) begin
        start_q[wr_idx] <= wr_rec.start;
        next_q[wr_idx]  <= wr_rec.next_line;
        mask_q[wr_idx]  <= wr_rec.mask;
        ferr_q[wr_idx]  <= wr_rec.fall_err;
      end
      if (fwd) rd_q <= wr_rec;
      else begin
        rd_q.start     <= start_q[rd_idx];
        rd_q.next_line <= next_q[rd_idx];
        rd_q.mask      <= mask_q[rd_idx];
        rd_q.fall_err  <= ferr_q[rd_idx];
      end
    end
  end

  assign rd_rec_o = rd_q;

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> start_q[$past(wr_idx)] == $past(wr_rec.start))
    else $error("write did not land in its entry");

  p_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_idx == rd_idx) |=> rd_q == $past(wr_rec))
    else $error("same-entry write not forwarded");

  p_read_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_idx == rd_idx) |=> rd_q.start == $past(start_q[rd_idx]))
    else $error("read register missed its entry");
endmodule

// File: rtl/pcs_expand.sv
module pcs_expand
  import pcs_pkg::*;
(
  input  rec_t              rec_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              cross_o
);
  logic [SUM_W:0]              sum;
  logic [ADDR_W-1:LINE_LSB]    base;

  assign sum     = {1'b0, rec_i.start[SUM_W:1]} + {{(SUM_W+1-OFF_W){1'b0}}, off_i};
  assign cross_o = rec_i.mask[off_i];
  assign base    = cross_o ? rec_i.next_line[ADDR_W-1:LINE_LSB]
                           : rec_i.start[ADDR_W-1:LINE_LSB];
  assign pc_o    = {base, sum[SUM_W-1:0], 1'b0};

  always_comb begin
    p_cross_needs_upper_r7: assert (!cross_o || rec_i.start[LINE_LSB-1])
      else $error("line crossing selected for a lower-half block");
  end
endmodule

// File: rtl/pc_block_store.sv
module pc_block_store
  import pcs_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_start,
  input  logic [ADDR_W-1:0] wr_next_line,
  input  logic              wr_fall_err,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  slot_off,
  output logic [ADDR_W-1:0] rd_start,
  output logic [ADDR_W-1:0] rd_next_line,
  output logic [SLOTS-1:0]  rd_mask,
  output logic              rd_fall_err,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_crosses
);
  logic [SLOTS-1:0] wr_mask;
  rec_t             wr_rec;
  rec_t             rd_rec;

  pcs_mask_gen u_mask (
    .start_i (wr_start),
    .mask_o  (wr_mask)
  );

  assign wr_rec = '{start: wr_start, next_line: wr_next_line,
                    mask: wr_mask, fall_err: wr_fall_err};

  pcs_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_idx   (wr_idx),
    .wr_rec   (wr_rec),
    .rd_idx   (rd_idx),
    .rd_rec_o (rd_rec)
  );

  pcs_expand u_expand (
    .rec_i   (rd_rec),
    .off_i   (slot_off),
    .pc_o    (pc_out),
    .cross_o (pc_crosses)
  );

  assign rd_start     = rd_rec.start;
  assign rd_next_line = rd_rec.next_line;
  assign rd_mask      = rd_rec.mask;
  assign rd_fall_err  = rd_rec.fall_err;

  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |=> (rd_start == '0 && rd_mask == '0 && !rd_fall_err))
    else $error("read register not cleared by reset");
endmodule

// File: tb/pc_block_store_tb_top.sv
module pc_block_store_tb_top;
  localparam int ENT = 8;
  localparam int IW  = $clog2(ENT);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [38:0] wr_start = '0;
  logic [38:0] wr_next_line = '0;
  logic        wr_fall_err = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [3:0]  slot_off = '0;
  logic [38:0] rd_start, rd_next_line, pc_out;
  logic [15:0] rd_mask;
  logic        rd_fall_err, pc_crosses;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pc_block_store #(.ENTRIES(ENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_start(wr_start), .wr_next_line(wr_next_line), .wr_fall_err(wr_fall_err),
    .rd_idx(rd_idx), .slot_off(slot_off), .rd_start(rd_start),
    .rd_next_line(rd_next_line), .rd_mask(rd_mask), .rd_fall_err(rd_fall_err),
    .pc_out(pc_out), .pc_crosses(pc_crosses)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_mask(input logic [38:0] s);
    logic [15:0] m;
    for (int n = 0; n < 16; n++) m[n] = (int'(s[5:1]) + n) > 31;
    return m;
  endfunction

  function automatic logic [38:0] exp_pc(input logic [38:0] s, input logic [38:0] nl,
                                         input int off);
    int sum;
    logic [4:0] low;
    sum = int'(s[5:1]) + off;
    low = 5'(sum % 32);
    return (sum > 31) ? {nl[38:6], low, 1'b0} : {s[38:6], low, 1'b0};
  endfunction

  task automatic do_write(input int idx, input logic [38:0] s, input logic [38:0] nl,
                          input logic fe);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = IW'(idx); wr_start = s; wr_next_line = nl; wr_fall_err = fe;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input int idx);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset start", 64'(rd_start), 64'd0);
    chk("R8 reset mask", 64'(rd_mask), 64'd0);
    chk("R8 reset pc", 64'(pc_out), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R5 R6 R7: sweep all low start bits and all slot offsets
    for (int lo = 0; lo < 64; lo++) begin
      logic [32:0] up;
      logic [38:0] s, nl;
      up = 33'(lo * 32'h09E3_779B + 5);
      s  = {up, 6'(lo)};
      nl = {up ^ 33'h1_5555_AAAA, 6'd0};
      do_write(lo % ENT, s, nl, lo[0]);
      do_read(lo % ENT);
      chk("R1 start", 64'(rd_start), 64'(s));
      chk("R1 next line", 64'(rd_next_line), 64'(nl));
      chk("R1 fall err", 64'(rd_fall_err), 64'(lo[0]));
      chk("R2 mask", 64'(rd_mask), 64'(exp_mask(s)));
      for (int o = 0; o < 16; o++) begin
        slot_off = 4'(o);
        #1;
        chk((int'(s[5:1]) + o > 31) ? "R7 pc next line" : "R5 R6 pc", 64'(pc_out),
            64'(exp_pc(s, nl, o)));
        chk("R6 R7 crosses", 64'(pc_crosses), 64'((int'(s[5:1]) + o) > 31));
      end
    end

    // R9: rewrite one entry, neighbour unchanged
    do_write(1, 39'h12_3456_7840, 39'h55_0000_0000, 1'b0);
    do_write(2, 39'h0A_BCDE_F020, 39'h66_0000_0000, 1'b1);
    do_write(1, 39'h7F_0000_1060, 39'h01_2345_6780, 1'b1);
    do_read(1);
    chk("R9 rewritten start", 64'(rd_start), 64'h7F_0000_1060);
    chk("R9 rewritten mask", 64'(rd_mask), 64'(exp_mask(39'h7F_0000_1060)));
    do_read(2);
    chk("R9 neighbour start", 64'(rd_start), 64'h0A_BCDE_F020);
    chk("R9 neighbour err", 64'(rd_fall_err), 64'd1);

    // R3: an address change only lands at the next edge
    @(negedge clk);
    rd_idx = IW'(1);
    #1;
    chk("R3 old entry held", 64'(rd_start), 64'h0A_BCDE_F020);
    @(posedge clk);
    #1;
    chk("R3 new entry loaded", 64'(rd_start), 64'h7F_0000_1060);

    // R4: same-entry write and read forward the new record
    @(negedge clk);
    rd_idx = IW'(2);
    wr_valid = 1'b1; wr_idx = IW'(2);
    wr_start = 39'h33_3333_3370; wr_next_line = 39'h44_4444_4400; wr_fall_err = 1'b0;
    @(posedge clk);
    #1;
    chk("R4 forwarded start", 64'(rd_start), 64'h33_3333_3370);
    chk("R4 forwarded mask", 64'(rd_mask), 64'(exp_mask(39'h33_3333_3370)));
    chk("R4 forwarded err", 64'(rd_fall_err), 64'd0);
    @(negedge clk);
    wr_valid = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule